// File: doc/BRIEF.md
# CCD Linear Sensor Timing Generator

This block produces all drive clocks for a two-phase CCD linear image sensor from one fast system clock. For each line it raises a transfer-gate pulse while shift phase 1 is held high. It waits a guard interval, then clocks the two complementary shift phases out one cell per half period. Copies of the two phases drive the last register stage. A reset-gate pulse marks the start of every cell.

Beside the clocks it outputs the index of the current readout cell and a 2-bit class tag: optical black, invalid or valid. A downstream sampler uses the tag to decide which converted samples to keep. The sensor layout is fixed by parameters: 18 black cells, 2 invalid, 5150 valid and 2 invalid, with the readout continuing to 5186 cells in total. All widths and gaps are given in system-clock cycles on static configuration inputs. While `run` is high, lines repeat at a programmable period. That period is never shorter than the line's own sequence.

Top module: `ccd_line_timer`

## Requirements
- R1: A synchronous reset puts the outputs in the safe state: transfer gate low, phase 1 high, phase 2 low, reset gate low, index 0, class 00, strobes and `cfg_err` low.
- R2: During readout, cell k lasts `px_half` cycles. Phase 1 equals bit 0 of k and phase 2 is its complement, so the first cell drives phase 1 low.
- R3: The reset gate is high for the first `rg_width` cycles of every readout cell and low at all other times.
- R4: A line starts with `setup_gap`+1 cycles of phase 1 high and the transfer gate low. The transfer gate then stays high for exactly `tg_width` cycles, and phase 1 stays high throughout.
- R5: After the transfer gate falls, phase 1 stays held high and phase 2 low for `guard_gap`+1 cycles before cell 0 begins.
- R6: The last-stage outputs equal phase 1 and phase 2 in every cycle.
- R7: `pix_idx` carries the current cell number and `pix_cls` its class: 01 for cells 0 to 17, 10 for cells 18 and 19, 11 for cells 20 to 5169, 10 for cells 5170 to 5185, and 00 outside readout.
- R8: Each line reads out exactly 5186 cells. After the last cell, phase 1 stays high and phase 2 low.
- R9: `sol` is high in the first cycle of each line. `line_done` is high in the one cycle that follows the last cell. The next line starts max(`line_period`, L+1) cycles after the previous start, where L is the number of cycles up to the end of the last cell.
- R10: If `tg_width` is below TG_MIN (25), or `px_half` is below 2, or `rg_width` is 0, or `rg_width` is not below `px_half`, then no line starts and `cfg_err` is high from the next cycle on. A configuration with `tg_width` equal to TG_MIN is accepted.
- R11: If `run` is low when the line period ends, the block returns to idle with the safe output levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Keep producing lines |
| setup_gap | input | 16 | Cycles, minus one, from phase 1 held to transfer-gate rise |
| tg_width | input | 16 | Transfer-gate high time in cycles |
| guard_gap | input | 16 | Cycles, minus one, from transfer-gate fall to first cell |
| px_half | input | 16 | Cycles per readout cell (half phase period) |
| rg_width | input | 16 | Reset-gate high time in cycles |
| line_period | input | 32 | Requested line period in cycles |
| tg | output | 1 | Transfer gate |
| ph1 | output | 1 | Shift phase 1 |
| ph2 | output | 1 | Shift phase 2 |
| ph1_last | output | 1 | Last-stage phase 1 |
| ph2_last | output | 1 | Last-stage phase 2 |
| rg | output | 1 | Reset gate |
| pix_idx | output | 13 | Current readout cell |
| pix_cls | output | 2 | Cell class tag |
| sol | output | 1 | Start-of-line strobe |
| line_done | output | 1 | Readout finished strobe |
| cfg_err | output | 1 | Configuration rejected |

## Verification
A wrong sequencer state or counter shows up in the same cycle as a wrong level on the drive clocks. Examples are a transfer gate that is one cycle short, a phase edge at the wrong cell boundary, or a reset-gate pulse of the wrong width. The bench compares every output in every cycle of complete lines against a model computed from the requirements, so such a fault is seen on its first cycle. A cell-counter fault reaches `pix_idx`, `pix_cls` and the phase parity at once. A fault in the line timer only shows up at the end of the line, in where `line_done` and the next `sol` fall.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_GUARD,
        ST_READ,
        ST_PAD
    } seq_st_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'b00,
        CLS_BLACK = 2'b01,
        CLS_INVAL = 2'b10,
        CLS_VALID = 2'b11
    } cell_cls_e;

endpackage

// File: rtl/ccd_cfg_check.sv
module ccd_cfg_check #(
    parameter int CFG_W  = 16,
    parameter int TG_MIN = 25
) (
    input  logic [CFG_W-1:0] tg_width,
    input  logic [CFG_W-1:0] px_half,
    input  logic [CFG_W-1:0] rg_width,
    output logic             cfg_ok
);
    localparam logic [CFG_W-1:0] TG_FLOOR = CFG_W'(TG_MIN);
    localparam logic [CFG_W-1:0] PX_FLOOR = CFG_W'(2);

    logic tg_ok, px_ok, rg_ok;

    always_comb begin
        tg_ok  = (tg_width >= TG_FLOOR);
        px_ok  = (px_half >= PX_FLOOR);
        rg_ok  = (rg_width != '0) && (rg_width < px_half);
        cfg_ok = tg_ok && px_ok && rg_ok;
    end
endmodule

// File: rtl/ccd_cell_class.sv
module ccd_cell_class
    import ccd_tg_pkg::*;
#(
    parameter int IDX_W   = 13,
    parameter int N_BLACK = 18,
    parameter int N_LEAD  = 2,
    parameter int N_VALID = 5150
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             active,
    output cell_cls_e        cls
);
    localparam int          END_BLACK_I = N_BLACK;
    localparam int          END_LEAD_I  = N_BLACK + N_LEAD;
    localparam int          END_VALID_I = N_BLACK + N_LEAD + N_VALID;
    localparam logic [IDX_W-1:0] END_BLACK = IDX_W'(END_BLACK_I);
    localparam logic [IDX_W-1:0] END_LEAD  = IDX_W'(END_LEAD_I);
    localparam logic [IDX_W-1:0] END_VALID = IDX_W'(END_VALID_I);

    always_comb begin
        if (!active)
            cls = CLS_NONE;
        else if (idx < END_BLACK)
            cls = CLS_BLACK;
        else if (idx < END_LEAD)
            cls = CLS_INVAL;
        else if (idx < END_VALID)
            cls = CLS_VALID;
        else
            cls = CLS_INVAL;
    end
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
    import ccd_tg_pkg::*;
#(
    parameter int CFG_W   = 16,
    parameter int LINE_W  = 32,
    parameter int IDX_W   = 13,
    parameter int N_CELLS = 5186
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cfg_ok,
    input  logic [CFG_W-1:0]  setup_gap,
    input  logic [CFG_W-1:0]  tg_width,
    input  logic [CFG_W-1:0]  guard_gap,
    input  logic [CFG_W-1:0]  px_half,
    input  logic [CFG_W-1:0]  rg_width,
    input  logic [LINE_W-1:0] line_period,
    input  cell_cls_e         cls_nxt,
    output logic [IDX_W-1:0]  idx_nxt,
    output logic              read_nxt,
    output logic              tg,
    output logic              ph1,
    output logic              ph2,
    output logic              ph1_last,
    output logic              ph2_last,
    output logic              rg,
    output logic [IDX_W-1:0]  pix_idx,
    output logic [1:0]        pix_cls,
    output logic              sol,
    output logic              line_done,
    output logic              cfg_err
);
    localparam logic [IDX_W-1:0] LAST_CELL = IDX_W'(N_CELLS - 1);
    localparam logic [LINE_W-1:0] LT_MAX   = {LINE_W{1'b1}};

    typedef struct packed {
        seq_st_e           st;
        logic [CFG_W-1:0]  cnt;
        logic [CFG_W-1:0]  sub;
        logic [IDX_W-1:0]  pix;
        logic [LINE_W-1:0] lt;
        logic              tg;
        logic              ph1;
        logic              ph2;
        logic              ph1l;
        logic              ph2l;
        logic              rg;
        logic              sol;
        logic              done;
        logic              err;
        cell_cls_e         cls;
    } seq_t;

    seq_t q, d;

    logic [CFG_W:0]  cnt_inc;
    logic [CFG_W:0]  sub_inc;
    logic [LINE_W:0] lt_inc;
    logic            start_ok;

    always_comb begin
        cnt_inc  = {1'b0, q.cnt} + (CFG_W+1)'(1);
        sub_inc  = {1'b0, q.sub} + (CFG_W+1)'(1);
        lt_inc   = {1'b0, q.lt} + (LINE_W+1)'(1);
        start_ok = run && cfg_ok;

        d      = q;
        d.sol  = 1'b0;
        d.done = 1'b0;
        d.err  = !cfg_ok;
        if (q.lt != LT_MAX)
            d.lt = lt_inc[LINE_W-1:0];

        unique case (q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    d.st  = ST_SETUP;
                    d.cnt = '0;
                    d.lt  = '0;
                    d.sol = 1'b1;
                end
            end
            ST_SETUP: begin
                if (q.cnt >= setup_gap) begin
                    d.st  = ST_XFER;
                    d.cnt = '0;
                end else begin
                    d.cnt = cnt_inc[CFG_W-1:0];
                end
            end
            ST_XFER: begin
                if (cnt_inc >= {1'b0, tg_width}) begin
                    d.st  = ST_GUARD;
                    d.cnt = '0;
                end else begin
                    d.cnt = cnt_inc[CFG_W-1:0];
                end
            end
            ST_GUARD: begin
                if (q.cnt >= guard_gap) begin
                    d.st  = ST_READ;
                    d.cnt = '0;
                    d.sub = '0;
                    d.pix = '0;
                end else begin
                    d.cnt = cnt_inc[CFG_W-1:0];
                end
            end
            ST_READ: begin
                if (sub_inc >= {1'b0, px_half}) begin
                    d.sub = '0;
                    if (q.pix == LAST_CELL) begin
                        d.st   = ST_PAD;
                        d.pix  = '0;
                        d.done = 1'b1;
                    end else begin
                        d.pix = q.pix + IDX_W'(1);
                    end
                end else begin
                    d.sub = sub_inc[CFG_W-1:0];
                end
            end
            ST_PAD: begin
                if (lt_inc >= {1'b0, line_period}) begin
                    if (start_ok) begin
                        d.st  = ST_SETUP;
                        d.cnt = '0;
                        d.lt  = '0;
                        d.sol = 1'b1;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        read_nxt = (d.st == ST_READ);
        idx_nxt  = d.pix;
        d.tg     = (d.st == ST_XFER);
        d.ph1    = read_nxt ? d.pix[0] : 1'b1;
        d.ph2    = read_nxt ? ~d.pix[0] : 1'b0;
        d.ph1l   = read_nxt ? d.pix[0] : 1'b1;
        d.ph2l   = read_nxt ? ~d.pix[0] : 1'b0;
        d.rg     = read_nxt && (d.sub < rg_width);
        d.cls    = cls_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ph1  <= 1'b1;
            q.ph1l <= 1'b1;
            q.cls  <= CLS_NONE;
        end else begin
            q <= d;
        end
    end

    assign tg        = q.tg;
    assign ph1       = q.ph1;
    assign ph2       = q.ph2;
    assign ph1_last  = q.ph1l;
    assign ph2_last  = q.ph2l;
    assign rg        = q.rg;
    assign pix_idx   = q.pix;
    assign pix_cls   = q.cls;
    assign sol       = q.sol;
    assign line_done = q.done;
    assign cfg_err   = q.err;
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_tg_pkg::*;
#(
    parameter int CFG_W   = 16,
    parameter int LINE_W  = 32,
    parameter int TG_MIN  = 25,
    parameter int N_BLACK = 18,
    parameter int N_LEAD  = 2,
    parameter int N_VALID = 5150,
    parameter int N_CELLS = 5186,
    parameter int IDX_W   = $clog2(N_CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CFG_W-1:0]  setup_gap,
    input  logic [CFG_W-1:0]  tg_width,
    input  logic [CFG_W-1:0]  guard_gap,
    input  logic [CFG_W-1:0]  px_half,
    input  logic [CFG_W-1:0]  rg_width,
    input  logic [LINE_W-1:0] line_period,
    output logic              tg,
    output logic              ph1,
    output logic              ph2,
    output logic              ph1_last,
    output logic              ph2_last,
    output logic              rg,
    output logic [IDX_W-1:0]  pix_idx,
    output logic [1:0]        pix_cls,
    output logic              sol,
    output logic              line_done,
    output logic              cfg_err
);
    logic             cfg_ok;
    logic [IDX_W-1:0] idx_nxt;
    logic             read_nxt;
    cell_cls_e        cls_nxt;

    ccd_cfg_check #(.CFG_W(CFG_W), .TG_MIN(TG_MIN)) u_cfg (
        .tg_width (tg_width),
        .px_half  (px_half),
        .rg_width (rg_width),
        .cfg_ok   (cfg_ok)
    );

    ccd_cell_class #(
        .IDX_W(IDX_W), .N_BLACK(N_BLACK), .N_LEAD(N_LEAD), .N_VALID(N_VALID)
    ) u_cls (
        .idx    (idx_nxt),
        .active (read_nxt),
        .cls    (cls_nxt)
    );

    ccd_line_seq #(
        .CFG_W(CFG_W), .LINE_W(LINE_W), .IDX_W(IDX_W), .N_CELLS(N_CELLS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cfg_ok      (cfg_ok),
        .setup_gap   (setup_gap),
        .tg_width    (tg_width),
        .guard_gap   (guard_gap),
        .px_half     (px_half),
        .rg_width    (rg_width),
        .line_period (line_period),
        .cls_nxt     (cls_nxt),
        .idx_nxt     (idx_nxt),
        .read_nxt    (read_nxt),
        .tg          (tg),
        .ph1         (ph1),
        .ph2         (ph2),
        .ph1_last    (ph1_last),
        .ph2_last    (ph2_last),
        .rg          (rg),
        .pix_idx     (pix_idx),
        .pix_cls     (pix_cls),
        .sol         (sol),
        .line_done   (line_done),
        .cfg_err     (cfg_err)
    );
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
    parameter int TG_MIN = 25,
    parameter int IDX_W  = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             tg,
    input logic             ph1,
    input logic             ph2,
    input logic             ph1_last,
    input logic             ph2_last,
    input logic             rg,
    input logic [IDX_W-1:0] pix_idx,
    input logic [1:0]       pix_cls,
    input logic             sol,
    input logic             cfg_err
);
    logic [15:0] tg_len_q;

    always_ff @(posedge clk) begin
        if (rst)
            tg_len_q <= '0;
        else if (tg && tg_len_q != 16'hFFFF)
            tg_len_q <= tg_len_q + 16'd1;
        else if (!tg)
            tg_len_q <= '0;
    end

    a_r2_phase_complement: assert property (@(posedge clk) disable iff (rst)
        ph1 != ph2);

    a_r6_last_stage_match: assert property (@(posedge clk) disable iff (rst)
        (ph1_last == ph1) && (ph2_last == ph2));

    a_r4_xfer_inside_ph1: assert property (@(posedge clk) disable iff (rst)
        tg |-> ph1);

    a_r4_xfer_rise_after_ph1: assert property (@(posedge clk) disable iff (rst)
        $rose(tg) |-> $past(ph1));

    a_r4_xfer_min_width: assert property (@(posedge clk) disable iff (rst)
        $fell(tg) |-> (tg_len_q >= 16'(TG_MIN)));

    a_r5_ph1_held_after_xfer: assert property (@(posedge clk) disable iff (rst)
        $fell(tg) |-> (ph1 && !rg));

    a_r3_rg_in_readout: assert property (@(posedge clk) disable iff (rst)
        rg |-> (pix_cls != 2'b00));

    a_r7_idx_step: assert property (@(posedge clk) disable iff (rst)
        ($rose(rg) && pix_idx != '0) |-> (pix_idx == $past(pix_idx) + IDX_W'(1)));

    a_r9_sol_single: assert property (@(posedge clk) disable iff (rst)
        sol |=> !sol);

    a_r10_err_blocks_start: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !sol);
endmodule

bind ccd_line_timer ccd_line_timer_chk #(.TG_MIN(TG_MIN), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tg       (tg),
    .ph1      (ph1),
    .ph2      (ph2),
    .ph1_last (ph1_last),
    .ph2_last (ph2_last),
    .rg       (rg),
    .pix_idx  (pix_idx),
    .pix_cls  (pix_cls),
    .sol      (sol),
    .cfg_err  (cfg_err)
);

// File: tb/ccd_line_timer_test.sv
module ccd_line_timer_test;
    localparam int NC = 5186;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] setup_gap = '0, tg_width = 16'd25, guard_gap = '0;
    logic [15:0] px_half = 16'd2, rg_width = 16'd1;
    logic [31:0] line_period = '0;
    logic        tg, ph1, ph2, ph1_last, ph2_last, rg, sol, line_done, cfg_err;
    logic [12:0] pix_idx;
    logic [1:0]  pix_cls;

    int n_chk = 0;
    int n_err = 0;

    ccd_line_timer uut (
        .clk(clk), .rst(rst), .run(run),
        .setup_gap(setup_gap), .tg_width(tg_width), .guard_gap(guard_gap),
        .px_half(px_half), .rg_width(rg_width), .line_period(line_period),
        .tg(tg), .ph1(ph1), .ph2(ph2), .ph1_last(ph1_last), .ph2_last(ph2_last),
        .rg(rg), .pix_idx(pix_idx), .pix_cls(pix_cls), .sol(sol),
        .line_done(line_done), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    function automatic logic [22:0] obs();
        return {tg, ph1, ph2, ph1_last, ph2_last, rg, sol, line_done, pix_cls, pix_idx};
    endfunction

    localparam logic [22:0] IDLE_VEC = {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 13'd0};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int seq_len();
        return (int'(setup_gap) + 1) + int'(tg_width) + (int'(guard_gap) + 1) + NC * int'(px_half);
    endfunction

    function automatic int line_len();
        int l0 = seq_len() + 1;
        return (int'(line_period) > l0) ? int'(line_period) : l0;
    endfunction

    function automatic logic [1:0] cls_of(int k);
        if (k < 18) return 2'b01;
        if (k < 20) return 2'b10;
        if (k < 5170) return 2'b11;
        return 2'b10;
    endfunction

    function automatic logic [22:0] expect_at(int t);
        int s = int'(setup_gap) + 1;
        int w = int'(tg_width);
        int g = int'(guard_gap) + 1;
        int r = NC * int'(px_half);
        logic e_tg = 1'b0, e_p1 = 1'b1, e_p2 = 1'b0, e_rg = 1'b0, e_sol = 1'b0, e_dn = 1'b0;
        logic [1:0] e_cls = 2'b00;
        logic [12:0] e_idx = '0;
        if (t == 0) e_sol = 1'b1;
        if (t < s) begin
        end else if (t < s + w) begin
            e_tg = 1'b1;
        end else if (t < s + w + g) begin
        end else if (t < s + w + g + r) begin
            int k = (t - s - w - g) / int'(px_half);
            int sb = (t - s - w - g) % int'(px_half);
            e_p1 = k[0];
            e_p2 = !k[0];
            e_rg = (sb < int'(rg_width));
            e_idx = 13'(k);
            e_cls = cls_of(k);
        end else if (t == s + w + g + r) begin
            e_dn = 1'b1;
        end
        return {e_tg, e_p1, e_p2, e_p1, e_p2, e_rg, e_sol, e_dn, e_cls, e_idx};
    endfunction

    function automatic string tag_at(int t);
        int s = int'(setup_gap) + 1;
        int w = int'(tg_width);
        int g = int'(guard_gap) + 1;
        int r = NC * int'(px_half);
        if (t < s + w) return "R4 setup/transfer";
        if (t < s + w + g) return "R5 guard";
        if (t >= s + w + g + r - int'(px_half) && t < s + w + g + r) return "R8 last cell";
        if (t < s + w + g + r) return "R2/R3/R6/R7 readout";
        return "R9 line end";
    endfunction

    task automatic run_lines(int nlines);
        int p = line_len();
        @(negedge clk);
        run = 1'b1;
        for (int ln = 0; ln < nlines; ln++) begin
            for (int t = 0; t < p; t++) begin
                @(negedge clk);
                check(tag_at(t), 32'(obs()), 32'(expect_at(t)));
                if (ln == nlines - 1 && t == p - 1) run = 1'b0;
            end
        end
        @(negedge clk);
        check("R11 idle after stop", 32'(obs()), 32'(IDLE_VEC));
        repeat (5) @(negedge clk);
        check("R11 stays idle", 32'(obs()), 32'(IDLE_VEC));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 32'(obs()), 32'(IDLE_VEC));
        check("R1 reset cfg_err", 32'(cfg_err), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", 32'(obs()), 32'(IDLE_VEC));

        // directed: minimum transfer width accepted, fastest cells
        setup_gap = 16'd2; tg_width = 16'd25; guard_gap = 16'd4;
        px_half = 16'd2; rg_width = 16'd1; line_period = 32'd0;
        @(negedge clk);
        @(negedge clk);
        check("R10 boundary width accepted", 32'(cfg_err), 32'd0);
        run_lines(1);

        // directed: padded line period, two lines back to back
        setup_gap = 16'd0; tg_width = 16'd40; guard_gap = 16'd0;
        px_half = 16'd3; rg_width = 16'd2;
        line_period = 32'(seq_len() + 1 + 37);
        run_lines(2);

        // random configurations
        for (int i = 0; i < 3; i++) begin
            setup_gap = 16'($urandom % 6);
            tg_width  = 16'(25 + $urandom % 20);
            guard_gap = 16'($urandom % 6);
            px_half   = 16'(2 + $urandom % 3);
            rg_width  = 16'(1 + $urandom % (int'(px_half) - 1));
            line_period = ($urandom % 2 == 0) ? 32'd0 : 32'(seq_len() + 1 + $urandom % 50);
            run_lines(1);
        end

        // rejected configurations
        tg_width = 16'd24; px_half = 16'd2; rg_width = 16'd1; line_period = '0;
        @(negedge clk);
        run = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            check("R10 short transfer blocks start", 32'(obs()), 32'(IDLE_VEC));
        end
        check("R10 cfg_err short transfer", 32'(cfg_err), 32'd1);
        run = 1'b0;
        tg_width = 16'd30; px_half = 16'd3; rg_width = 16'd3;
        @(negedge clk);
        run = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check("R10 reset gate too wide blocks start", 32'(obs()), 32'(IDLE_VEC));
        end
        check("R10 cfg_err reset gate width", 32'(cfg_err), 32'd1);
        run = 1'b0;

        // reset in the middle of readout
        setup_gap = 16'd1; tg_width = 16'd30; guard_gap = 16'd1;
        px_half = 16'd2; rg_width = 16'd1; line_period = '0;
        @(negedge clk);
        run = 1'b1;
        for (int t = 0; t < 201; t++) begin
            @(negedge clk);
            if (t == 200) check("R2 before reset", 32'(obs()), 32'(expect_at(t)));
        end
        run = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-line reset", 32'(obs()), 32'(IDLE_VEC));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 idle after mid-line reset", 32'(obs()), 32'(IDLE_VEC));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule